// File: doc/BRIEF.md
# Table-Driven GPIO Sequence Runner

This block plays back short, fixed lists of output-line operations for a power-control path. Each operation names one control line, the level to drive on it, and a wait in milliseconds before the next operation may run. The lists are held in a small constant table inside the block. A start strobe, together with a two-bit selector, picks one of four lists. The block reports completion with a one-cycle done pulse.

The runner owns a register of control lines. A line keeps its value until an operation addresses it. Reset values come from a parameter. Waits are counted in strobes of a 1 ms tick input, so the clock frequency does not enter the tables. All pins are plain control and status signals. Nothing flows through the block as a data stream, so there is no valid/ready handshake: a start that arrives while a list is running is simply dropped.

Top module: `gpio_seq_runner`

## Requirements
- R1: While reset is held and right after it, `lines_o` equals the RESET_VAL parameter, and `busy_o` and `done_o` are 0.
- R2: A `start_i` sampled high while idle latches `sel_i`, and `busy_o` is high from the next cycle. `done_o` is high for exactly one cycle, which is the first cycle in which `busy_o` is low again.
- R3: Operations run strictly in list order. The first one takes effect at the clock edge after the start edge. Each one sets only the addressed line, and all other lines keep their values.
- R4: After an operation with a nonzero delay D, the next operation (or done) takes effect at the clock edge after the edge that samples the D-th `tick_i` strobe. Tick strobes sampled during the same edge that applies the operation are not counted.
- R5: After an operation with a zero delay, the next operation (or done) takes effect on the very next clock edge.
- R6: An empty list raises `done_o` on the cycle after the start edge, and `busy_o` is high for one cycle only.
- R7: A `start_i` pulse while busy is ignored. The running list, its timing and the lines are unaffected.
- R8: An operation whose line index is 16 or more (≥ N_LINES) changes no line, but its delay is still honoured.
- R9: The list contents are as follows. Each entry is written as (line, level, delay ms).
  - Selector 0 (power-up): (0,1,0) then (1,1,2).
  - Selector 1 (power-down): (1,0,0) then (0,0,3).
  - Selector 2: empty.
  - Selector 3: (15,1,0), then (200,1,1), then (15,0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, acted on only while idle |
| sel_i | input | 2 | List selector, sampled with start_i |
| tick_i | input | 1 | One-cycle strobe every millisecond |
| busy_o | output | 1 | High while a list is running |
| done_o | output | 1 | One-cycle pulse when a list finishes |
| lines_o | output | 16 | Control line register |

## Verification
A wrong step counter or list decode shows at `lines_o` on the edge after the start edge. The symptom is a line that changes out of order, or an extra line that changes. A wait counter that is off by one moves the next line change, or the done pulse, by a whole tick period. That error appears within one tick of the expected edge. A state machine that accepts a start while busy changes the line pattern on the edge after the stray strobe. Every edge of every run is compared, so each of these faults is caught within one tick period of where it occurs.

// File: rtl/gsr_pkg.sv
package gsr_pkg;
  localparam int IDX_W     = 8;
  localparam int DLY_W     = 8;
  localparam int NUM_LISTS = 4;
  localparam int MAX_STEPS = 3;
  localparam int SEL_W     = $clog2(NUM_LISTS);
  localparam int STEP_W    = $clog2(MAX_STEPS + 1);

  typedef struct packed {
    logic [IDX_W-1:0] line;
    logic             level;
    logic [DLY_W-1:0] delay_ms;
  } gsr_op_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_WAIT = 2'd2
  } gsr_state_t;

  function automatic gsr_op_t mk_op(input int ln, input bit lv, input int dl);
    gsr_op_t o;
    o.line     = IDX_W'(ln);
    o.level    = lv;
    o.delay_ms = DLY_W'(dl);
    return o;
  endfunction
endpackage

// File: rtl/gsr_rom.sv
module gsr_rom
  import gsr_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic [STEP_W-1:0] step,
  output gsr_op_t           op,
  output logic [STEP_W-1:0] len
);
  always_comb begin
    op  = mk_op(0, 1'b0, 0);
    len = '0;
    case (sel)
      SEL_W'(0): begin
        len = STEP_W'(2);
        case (step)
          STEP_W'(0): op = mk_op(0, 1'b1, 0);
          STEP_W'(1): op = mk_op(1, 1'b1, 2);
          default:    op = mk_op(0, 1'b0, 0);
        endcase
      end
      SEL_W'(1): begin
        len = STEP_W'(2);
        case (step)
          STEP_W'(0): op = mk_op(1, 1'b0, 0);
          STEP_W'(1): op = mk_op(0, 1'b0, 3);
          default:    op = mk_op(0, 1'b0, 0);
        endcase
      end
      SEL_W'(2): len = '0;
      default: begin
        len = STEP_W'(3);
        case (step)
          STEP_W'(0): op = mk_op(15, 1'b1, 0);
          STEP_W'(1): op = mk_op(200, 1'b1, 1);
          STEP_W'(2): op = mk_op(15, 1'b0, 0);
          default:    op = mk_op(0, 1'b0, 0);
        endcase
      end
    endcase
  end
endmodule

// File: rtl/gsr_ms_timer.sv
module gsr_ms_timer
  import gsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load)                   cnt_q <= load_val;
    else if (tick && cnt_q != '0)    cnt_q <= cnt_q - DLY_W'(1);
  end

  assign expire = tick && !load && (cnt_q == DLY_W'(1));

  // R4
  cnt_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> (cnt_q == '0 || $past(load)));
endmodule

// File: rtl/gsr_line_bank.sv
module gsr_line_bank
  import gsr_pkg::*;
#(
  parameter int              N_LINES   = 16,
  parameter logic [N_LINES-1:0] RESET_VAL = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_level,
  output logic [N_LINES-1:0] lines
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)                                lines[i] <= RESET_VAL[i];
      else if (wr_en && wr_idx == IDX_W'(i))     lines[i] <= wr_level;
    end
  end

  // R3
  one_line_per_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ($countones(lines ^ $past(lines)) <= 1));

  // R8
  out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx >= IDX_W'(N_LINES)) |=> $stable(lines));
endmodule

// File: rtl/gpio_seq_runner.sv
module gpio_seq_runner
  import gsr_pkg::*;
#(
  parameter int                 N_LINES   = 16,
  parameter logic [N_LINES-1:0] RESET_VAL = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               tick_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [N_LINES-1:0] lines_o
);
  gsr_state_t        state_q;
  logic [SEL_W-1:0]  sel_q;
  logic [STEP_W-1:0] step_q;
  logic              done_q;
  gsr_op_t           op;
  logic [STEP_W-1:0] len;
  logic              at_end;
  logic              wr_en;
  logic              expire;

  gsr_rom u_rom (
    .sel  (sel_q),
    .step (step_q),
    .op   (op),
    .len  (len)
  );

  assign at_end = (step_q == len);
  assign wr_en  = (state_q == ST_EXEC) && !at_end;

  gsr_ms_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_en),
    .load_val (op.delay_ms),
    .tick     (tick_i),
    .expire   (expire)
  );

  gsr_line_bank #(
    .N_LINES   (N_LINES),
    .RESET_VAL (RESET_VAL)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (op.line),
    .wr_level (op.level),
    .lines    (lines_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          sel_q   <= sel_i;
          step_q  <= '0;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          if (at_end) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else if (op.delay_ms == '0) begin
            step_q <= step_q + STEP_W'(1);
          end else begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: if (expire) begin
          step_q  <= step_q + STEP_W'(1);
          state_q <= ST_EXEC;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  // R2
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3
  idle_lines_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(lines_o));

  // R7
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(sel_q));

  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !tick_i) |=> ($stable(step_q) && state_q == ST_WAIT));
endmodule

// File: tb/gpio_seq_runner_test.sv
module gpio_seq_runner_test;
  localparam int N = 16;
  localparam logic [N-1:0] RV = 16'hA5C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] sel_i = '0;
  logic tick_i = 1'b0;
  logic busy_o, done_o;
  logic [N-1:0] lines_o;

  int checks = 0;
  int failures = 0;
  logic [N-1:0] cur;

  always #10 clk = ~clk;

  gpio_seq_runner #(.N_LINES(N), .RESET_VAL(RV)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i),
    .tick_i(tick_i), .busy_o(busy_o), .done_o(done_o), .lines_o(lines_o)
  );

  // R9 list contents as the bench understands them
  function automatic int bt_len(int s);
    case (s) 0: return 2; 1: return 2; 2: return 0; default: return 3; endcase
  endfunction
  function automatic int bt_line(int s, int k);
    if (s == 0) return (k == 0) ? 0 : 1;
    if (s == 1) return (k == 0) ? 1 : 0;
    return (k == 1) ? 200 : 15;
  endfunction
  function automatic bit bt_lvl(int s, int k);
    if (s == 0) return 1'b1;
    if (s == 1) return 1'b0;
    return (k == 2) ? 1'b0 : 1'b1;
  endfunction
  function automatic int bt_dly(int s, int k);
    if (s == 0) return (k == 1) ? 2 : 0;
    if (s == 1) return (k == 1) ? 3 : 0;
    if (s == 3) return (k == 1) ? 1 : 0;
    return 0;
  endfunction

  task automatic check(bit ok, string req, logic [N+1:0] act, logic [N+1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Runs list s with ticks every P edges; optionally injects a stray start (R7)
  task automatic run_list(int s, int p, bit inject);
    int app[3];
    int t, e, c, done_edge, ln;
    logic [N-1:0] expv;
    t = 1;
    for (int k = 0; k < bt_len(s); k++) begin
      app[k] = t;
      if (bt_dly(s, k) > 0) begin
        e = t; c = 0;
        while (c < bt_dly(s, k)) begin
          e++;
          if (e % p == 0) c++;
        end
        t = e + 1;
      end else begin
        t = t + 1;
      end
    end
    done_edge = t;
    @(negedge clk);
    start_i = 1'b1; sel_i = 2'(s); tick_i = 1'b0;
    for (int n = 0; n <= done_edge + 1; n++) begin
      @(negedge clk);
      expv = cur;
      for (int k = 0; k < bt_len(s); k++) begin
        ln = bt_line(s, k);
        if (app[k] <= n && ln < N) expv[ln] = bt_lvl(s, k);
      end
      // R3 R4 R5 R8 R9: line pattern after edge n
      check(lines_o === expv, (s == 3) ? "R8/R3" : (p == 1 ? "R5/R9" : "R4/R3"),
            {2'b00, lines_o}, {2'b00, expv});
      // R2 R6: busy and done timing
      check(busy_o === (n < done_edge) && done_o === (n == done_edge),
            (bt_len(s) == 0) ? "R6" : "R2",
            {busy_o, done_o, {N{1'b0}}},
            {(n < done_edge), (n == done_edge), {N{1'b0}}});
      start_i = inject && (n + 1 == 2) && (done_edge > 2);
      sel_i   = 2'((s + 1) % 4);   // R7 stray start with another selector
      tick_i  = ((n + 1) % p == 0);
    end
    start_i = 1'b0; tick_i = 1'b0;
    cur = lines_o;
  endtask

  initial begin
    #2_000_000;
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while held
    check(lines_o === RV && !busy_o && !done_o, "R1",
          {busy_o, done_o, lines_o}, {2'b00, RV});
    rst_n = 1'b1;
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    // R1: ticks while idle leave the state untouched
    check(lines_o === RV && !busy_o && !done_o, "R1",
          {busy_o, done_o, lines_o}, {2'b00, RV});
    cur = RV;
    for (int p = 1; p <= 3; p++)
      for (int s = 0; s < 4; s++)
        run_list(s, p, (p == 2));
    // R7: sweep again with stray starts at every tick spacing
    for (int s = 0; s < 4; s++) run_list(s, 1, 1'b1);
    for (int s = 3; s >= 0; s--) run_list(s, 3, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule